// File: doc/BRIEF.md
# Ethernet PHY Management Frame Master

This block runs one register access on an Ethernet PHY over the two-wire serial management interface (a management clock and a shared, bidirectional data line). The host pulses a start strobe with a read/write select, a 5-bit register number and, for a write, a 16-bit value. The block then builds the whole frame by itself: a long run of idle ones, the start pattern, the opcode, a PHY address of zero, the register number, the turnaround and the 16 data bits. It drives the data line through an output-enable so that the line can be turned around for reads.

The management clock is the system clock divided by the parameter `DIV`. Each frame bit spends `DIV/2` system cycles with the clock low, during which the bit is presented, and `DIV/2` cycles with the clock high. On a read, the block captures the PHY's data bits from the data input at the end of each high phase and presents the 16-bit result when the frame ends. A one-cycle done pulse marks the end of every frame. The busy output stays high for the whole frame.

Top module: `mgmt_frame_master`

## Requirements
- R1: Every frame opens with 33 management clock cycles in which the output enable is high and the data line is driven to 1.
- R2: After the idle ones the block drives the start pattern 0 then 1, then the opcode: 0,1 for a write (rd_i=0) and 1,0 for a read (rd_i=1).
- R3: After the opcode come five 0 bits of PHY address, then the 5 bits of reg_i, most significant bit first.
- R4: A write frame drives the turnaround bits 1 then 0, then the 16 bits of wdata_i most significant bit first, for 65 management clock cycles in total.
- R5: A read frame drops the output enable from bit 47 onward. It gives one clock cycle that is not sampled, then samples 16 bits from mdio_in_i most significant bit first, for 64 cycles in total. rdata_o carries those 16 bits after done_o.
- R6: One management clock period spans DIV system cycles, low for the first half and high for the second. The data output and the output enable change only while the management clock is low.
- R7: A start strobe that arrives while busy_o is high is ignored, and the frame in progress completes unchanged.
- R8: done_o is high for exactly one system cycle after the final bit, in the cycle where busy_o falls. This is the system cycle after the edge that ends bit number len*DIV after the accepting edge. rdata_o changes only in that cycle.
- R9: Between frames the management clock is low, the output enable is low and busy_o is low.
- R10: Reset, including reset in the middle of a frame, returns the block to idle with the clock low, the output enable low and busy_o and done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for one frame |
| rd_i | input | 1 | 1 selects a read, 0 selects a write |
| reg_i | input | 5 | PHY register number |
| wdata_i | input | 16 | Value for a write |
| rdata_o | output | 16 | Value captured by the last read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| mdc_o | output | 1 | Management clock |
| mdio_oe_o | output | 1 | Output enable for the data line |
| mdio_out_o | output | 1 | Value driven on the data line |
| mdio_in_i | input | 1 | Data line as seen by the block |

## Verification
Register numbers 0 and 31 and write values of all zeros, all ones and alternating patterns are sent as directed frames. These show whether the address bits and data bits go out in the right order and whether a bit is lost at either end of a field. Random frames that mix reads and writes check the opcode and the turnaround choice against the direction. Read data such as 0x8001 and random PHY values separate an off-by-one sampling point from correct capture. A start pulse in the middle of a frame and a reset in the middle of a frame exercise the ignore and recovery paths. A write that follows a read shows that rdata_o holds its value.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int REG_W       = 5;
  localparam int DATA_W      = 16;
  localparam int PHY_W       = 5;
  localparam int PRE_LEN     = 33;
  localparam int OFS_START   = PRE_LEN;
  localparam int OFS_OP      = OFS_START + 2;
  localparam int OFS_PHY     = OFS_OP + 2;
  localparam int OFS_REG     = OFS_PHY + PHY_W;
  localparam int OFS_TA      = OFS_REG + REG_W;
  localparam int OFS_RD_DATA = OFS_TA + 1;
  localparam int LEN_WR      = OFS_TA + 2 + DATA_W;
  localparam int LEN_RD      = OFS_TA + 1 + DATA_W;
  localparam int IDX_W       = $clog2(LEN_WR);

  typedef struct packed {
    logic oe;
    logic dout;
  } pin_t;

  // Number of management clock cycles in a frame of the given direction.
  function automatic int frame_len(input logic rd);
    return rd ? LEN_RD : LEN_WR;
  endfunction

  // Line state for bit position i of a frame.
  function automatic pin_t frame_pin(input logic rd,
                                     input logic [REG_W-1:0] ra,
                                     input logic [DATA_W-1:0] wd,
                                     input int i);
    pin_t p;
    p.oe   = 1'b1;
    p.dout = 1'b0;
    if (i < OFS_START) begin
      p.dout = 1'b1;
    end else if (i == OFS_START) begin
      p.dout = 1'b0;
    end else if (i == OFS_START + 1) begin
      p.dout = 1'b1;
    end else if (i == OFS_OP) begin
      p.dout = rd;
    end else if (i == OFS_OP + 1) begin
      p.dout = ~rd;
    end else if (i < OFS_REG) begin
      p.dout = 1'b0;
    end else if (i < OFS_TA) begin
      for (int j = 0; j < REG_W; j++)
        if (i == OFS_TA - 1 - j) p.dout = ra[j];
    end else if (rd) begin
      p.oe   = 1'b0;
      p.dout = 1'b0;
    end else if (i == OFS_TA) begin
      p.dout = 1'b1;
    end else if (i == OFS_TA + 1) begin
      p.dout = 1'b0;
    end else begin
      for (int j = 0; j < DATA_W; j++)
        if (i == LEN_WR - 1 - j) p.dout = wd[j];
    end
    return p;
  endfunction

endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic bit_last
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc      = run && (cnt >= CW'(HALF));
  assign bit_last = run && (cnt == CW'(DIV - 1));

  // R6: the clock enters every frame from its low phase
  assert_clock_starts_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> !mdc);

  // R6: the end of a bit is always seen with the clock high
  assert_bit_ends_high_R6: assert property (@(posedge clk) disable iff (rst)
    bit_last |-> mdc);

endmodule

// File: rtl/mgmt_bit_seq.sv
module mgmt_bit_seq
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_in,
  input  logic [REG_W-1:0]  reg_in,
  input  logic [DATA_W-1:0] wd_in,
  input  logic              bit_last,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_l,
  output logic              frame_end,
  output logic              done,
  output logic              oe,
  output logic              dout
);
  logic [REG_W-1:0]  reg_l;
  logic [DATA_W-1:0] wd_l;
  logic              accept;
  pin_t              pin;

  assign accept    = start && !busy;
  assign frame_end = busy && bit_last && (int'(idx) == frame_len(rd_l) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      rd_l  <= 1'b0;
      reg_l <= '0;
      wd_l  <= '0;
      done  <= 1'b0;
    end else begin
      done <= frame_end;
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        rd_l  <= rd_in;
        reg_l <= reg_in;
        wd_l  <= wd_in;
      end else if (frame_end) begin
        busy <= 1'b0;
        idx  <= '0;
      end else if (busy && bit_last) begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    pin = busy ? frame_pin(rd_l, reg_l, wd_l, int'(idx)) : pin_t'('0);
  end

  assign oe   = pin.oe;
  assign dout = pin.dout;

  // R7: a strobe during a frame leaves the latched request untouched
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(reg_l) && $stable(rd_l) && $stable(wd_l)));

  // R8: done never lasts longer than one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done coincides with the fall of busy
  assert_done_with_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $fell(busy)));

endmodule

// File: rtl/mgmt_rx_capture.sv
module mgmt_rx_capture
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              rd_l,
  input  logic              bit_last,
  input  logic [IDX_W-1:0]  idx,
  input  logic              frame_end,
  input  logic              line_oe,
  input  logic              mdi,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sh;
  logic              sample_en;

  assign sample_en = busy && rd_l && bit_last && (int'(idx) >= OFS_RD_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      rdata <= '0;
    end else begin
      if (sample_en) sh <= {sh[DATA_W-2:0], mdi};
      if (sample_en && frame_end) rdata <= {sh[DATA_W-2:0], mdi};
    end
  end

  // R5: the block never samples while it drives the line
  assert_sample_released_R5: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> !line_oe);

  // R8: read data only moves at the end of a frame
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(rdata));

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_oe_o,
  output logic              mdio_out_o,
  input  logic              mdio_in_i
);
  logic             busy;
  logic             bit_last;
  logic             frame_end;
  logic             rd_l;
  logic [IDX_W-1:0] idx;

  mgmt_clk_div #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc_o),
    .bit_last (bit_last)
  );

  mgmt_bit_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .rd_in     (rd_i),
    .reg_in    (reg_i),
    .wd_in     (wdata_i),
    .bit_last  (bit_last),
    .busy      (busy),
    .idx       (idx),
    .rd_l      (rd_l),
    .frame_end (frame_end),
    .done      (done_o),
    .oe        (mdio_oe_o),
    .dout      (mdio_out_o)
  );

  mgmt_rx_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .rd_l      (rd_l),
    .bit_last  (bit_last),
    .idx       (idx),
    .frame_end (frame_end),
    .line_oe   (mdio_oe_o),
    .mdi       (mdio_in_i),
    .rdata     (rdata_o)
  );

  assign busy_o = busy;

  // R6: line changes only happen with the clock low
  assert_line_moves_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_out_o) || !$stable(mdio_oe_o)) |-> !mdc_o);

  // R9: an idle block keeps the clock low and the line released
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R5: once a read passes its register field the line stays released
  assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_l && int'(idx) >= OFS_TA) |-> !mdio_oe_o);

  // R10: the cycle after reset is idle
  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !mdc_o && !mdio_oe_o));

endmodule

// File: tb/sim_mgmt_frame_master.sv
module sim_mgmt_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  reg_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, mdc_o, mdio_oe_o, mdio_out_o;
  logic        mdio_in_i = 1'b0;

  mgmt_frame_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i), .reg_i(reg_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o),
    .mdc_o(mdc_o), .mdio_oe_o(mdio_oe_o), .mdio_out_o(mdio_out_o),
    .mdio_in_i(mdio_in_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // ---- line monitor and PHY model ----
  logic        rec_oe [0:79];
  logic        rec_do [0:79];
  int          nrise, ndone, hi_moves, bad_period, cyc, last_rise;
  logic        p_mdc, p_oe, p_do, p_done;
  logic [15:0] phy_data;
  bit          mon_on = 1'b0;

  task automatic clear_mon();
    nrise = 0; ndone = 0; hi_moves = 0; bad_period = 0; cyc = 0; last_rise = -1;
    p_mdc = mdc_o; p_oe = mdio_oe_o; p_do = mdio_out_o; p_done = done_o;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (mdc_o && !p_mdc) begin
        if (nrise < 80) begin
          rec_oe[nrise] = mdio_oe_o;
          rec_do[nrise] = mdio_out_o;
        end
        if (last_rise >= 0 && cyc - last_rise != DIV) bad_period++;
        last_rise = cyc;
        nrise++;
      end
      if (!mdc_o && p_mdc) begin
        if (nrise >= 48 && nrise < 64) mdio_in_i = phy_data[63 - nrise];
        else mdio_in_i = 1'b0;
      end
      if (mdc_o && (mdio_oe_o != p_oe || mdio_out_o != p_do)) hi_moves++;
      if (done_o) ndone++;
      p_mdc = mdc_o; p_oe = mdio_oe_o; p_do = mdio_out_o; p_done = done_o;
    end
  end

  // ---- expected frame, built as one concatenation ----
  task automatic expect_bit(input logic rd, input logic [4:0] ra, input logic [15:0] wd,
                            input int i, output logic eoe, output logic edo);
    logic [64:0] wseq;
    logic [46:0] rseq;
    wseq = {{33{1'b1}}, 2'b01, 2'b01, 5'b00000, ra, 2'b10, wd};
    rseq = {{33{1'b1}}, 2'b01, 2'b10, 5'b00000, ra};
    if (!rd) begin eoe = 1'b1; edo = wseq[64 - i]; end
    else if (i < 47) begin eoe = 1'b1; edo = rseq[46 - i]; end
    else begin eoe = 1'b0; edo = 1'b0; end
  endtask

  // One frame; mid_start pulses a conflicting start in the middle (R7).
  task automatic run_frame(input logic rd, input logic [4:0] ra, input logic [15:0] wd,
                           input logic [15:0] pd, input bit mid_start);
    int lat, elen, bad_pre, bad_hdr, bad_tail, first_bad;
    logic eoe, edo;
    logic [15:0] old_rdata;
    @(negedge clk);
    old_rdata = rdata_o;
    phy_data = pd;
    clear_mon();
    mon_on = 1'b1;
    rd_i = rd; reg_i = ra; wdata_i = wd; start_i = 1'b1;
    lat = 0;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 2000) begin
      if (mid_start && lat == 300) begin
        rd_i = ~rd; reg_i = ~ra; wdata_i = ~wd; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    elen = rd ? 64 : 65;
    check(lat == elen * DIV + 1, "R8", "done latency", lat, elen * DIV + 1);
    check(busy_o == 1'b0, "R8", "busy low with done", busy_o, 0);
    if (!rd) check(rdata_o == old_rdata, "R8", "rdata held over write", rdata_o, old_rdata);
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    check(nrise == elen, rd ? "R5" : "R4", "clock cycles in frame", nrise, elen);
    bad_pre = 0; bad_hdr = 0; bad_tail = 0; first_bad = -1;
    for (int i = 0; i < elen && i < 80; i++) begin
      expect_bit(rd, ra, wd, i, eoe, edo);
      if (rec_oe[i] !== eoe || (eoe && rec_do[i] !== edo)) begin
        if (first_bad < 0) first_bad = i;
        if (i < 33) bad_pre++;
        else if (i < 47) bad_hdr++;
        else bad_tail++;
      end
    end
    check(bad_pre == 0, "R1", "preamble bit errors", bad_pre, 0);
    check(bad_hdr == 0, "R2", "start/opcode/address errors (R3), first bad bit", first_bad, -1);
    check(bad_tail == 0, rd ? "R5" : "R4", "turnaround/data errors", bad_tail, 0);
    if (rd) check(rdata_o == pd, "R5", "captured read data", rdata_o, pd);
    check(hi_moves == 0, "R6", "line changes with clock high", hi_moves, 0);
    check(bad_period == 0, "R6", "clock period mismatches", bad_period, 0);
    check(ndone == 1, "R8", "done pulse width", ndone, 1);
    check(!mdc_o && !mdio_oe_o && !busy_o, "R9", "idle after frame",
          {mdc_o, mdio_oe_o, busy_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mdc_o && !mdio_oe_o && !busy_o && !done_o && rdata_o == 16'h0,
          "R10", "reset state", {mdc_o, mdio_oe_o, busy_o, done_o}, 0);

    // directed corners
    run_frame(1'b0, 5'd0,  16'h0000, 16'h0000, 1'b0);
    run_frame(1'b0, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
    run_frame(1'b0, 5'd10, 16'hA5A5, 16'h0000, 1'b0);
    run_frame(1'b1, 5'd1,  16'h0000, 16'h8001, 1'b0);
    run_frame(1'b0, 5'd21, 16'h5A5A, 16'h0000, 1'b0);  // R8 rdata held
    run_frame(1'b1, 5'd31, 16'h0000, 16'hFFFF, 1'b0);
    run_frame(1'b1, 5'd0,  16'h0000, 16'h0000, 1'b0);
    // R7: conflicting start mid-frame, both directions
    run_frame(1'b0, 5'd18, 16'h1234, 16'h0000, 1'b1);
    run_frame(1'b1, 5'd7,  16'h0000, 16'hC3E1, 1'b1);

    // random mix
    for (int k = 0; k < 16; k++) begin
      run_frame(1'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end

    // R10: reset in the middle of a frame
    @(negedge clk);
    rd_i = 1'b0; reg_i = 5'd3; wdata_i = 16'hBEEF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (200) @(negedge clk);
    check(busy_o == 1'b1, "R10", "busy before mid-frame reset", busy_o, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!mdc_o && !mdio_oe_o && !busy_o && !done_o, "R10", "idle during reset",
          {mdc_o, mdio_oe_o, busy_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mdc_o && !mdio_oe_o && !busy_o && !done_o, "R10", "idle after reset",
          {mdc_o, mdio_oe_o, busy_o, done_o}, 0);
    run_frame(1'b1, 5'd9, 16'h0000, 16'h6B2D, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule